// File: doc/BRIEF.md
# Flash Program and Bulk-Erase Pulse Sequencer

This block times the write side of a flash array whose high programming voltage comes from an off-chip supply. A host hands it one command: write a byte, write an even-aligned 16-bit word, or wipe the whole array. The sequencer then drives the array's write or wipe strobe for a fixed number of clock cycles and waits a fixed settling time. It then reads the array back and compares. A location is written again and again until it reads back correctly, up to a pulse budget. Once the read-back matches, the block applies as many extra pulses as were needed to get there, which doubles the charge margin. A wipe works the same way, with its own longer timings, its own budget, and a read-back scan across every word of the array.

All durations are given in microseconds and scaled by a clock-rate parameter, so the same code serves any system clock. The command port is a valid/ready channel. `cmd_ready` is high only while the sequencer is idle. A command transfers on a cycle where `cmd_valid` and `cmd_ready` are both high. The host may hold `cmd_valid` for as long as it likes while `cmd_ready` is low, and nothing is taken until the sequencer returns to idle. A supply-good input gates the whole operation. Results are reported as single-cycle `done` or `fail` pulses.

Top module: `flash_pulse_seq`

## Requirements
- R1: `cmd_ready` is high exactly when `busy` is low. A command transfers only on a cycle with `cmd_valid` and `cmd_ready` both high. A `cmd_valid` presented while busy is ignored: it starts no pulse and leaves the array untouched.
- R2: `cmd_op` encodes 2'b00 = write byte, 2'b01 = write aligned word, 2'b10 = bulk erase, 2'b11 = reserved. A word write whose address has bit 0 set, or a reserved code, is refused: `fail` pulses in the cycle after the transfer, `busy` stays low, and no strobe is driven.
- R3: Each write pulse holds `arr_prog_en` high for exactly PROG_PULSE_US*CYC_PER_US cycles. Low gaps between consecutive write pulses are at least PROG_SETTLE_US*CYC_PER_US cycles.
- R4: Write verification compares only the enabled lanes. `arr_rdata[15:8]` holds the even byte and `[7:0]` the odd byte of the addressed word. A byte write at an even address drives `arr_be`=2'b10, and at an odd address 2'b01. A word write drives 2'b11. The bytes outside the enabled lanes are never altered.
- R5: If the read-back first matches after n write pulses, exactly n further pulses follow. Then `done` pulses, for a total of 2n write pulses.
- R6: If the read-back still mismatches after PROG_MAX write pulses, `fail` pulses and no further pulse is issued.
- R7: Each erase pulse holds `arr_erase_en` high for exactly ERASE_PULSE_US*CYC_PER_US cycles. A settle of ERASE_SETTLE_US*CYC_PER_US cycles follows each pulse. Verification passes only if every word of the array reads 16'hFFFF, and all array bytes are 8'hFF at `done`.
- R8: Erase has its own budget of ERASE_MAX pulses and its own margin of n extra pulses after a pass at pulse n. If the scan still fails after ERASE_MAX pulses, `fail` pulses.
- R9: If `vpp_ok` is low when a command transfers, `fail` pulses without any strobe. If `vpp_ok` goes low while busy, both strobes are low and `fail` pulses in the next cycle.
- R10: `busy` rises in the cycle after a transfer and falls in the cycle in which `done` or `fail` pulses. Each of `done` and `fail` lasts one cycle, and they are never high together. The two strobes are mutually exclusive and only high while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Host command valid |
| cmd_ready | output | 1 | Sequencer can take a command (idle) |
| cmd_op | input | 2 | Operation code (see R2) |
| cmd_addr | input | ADDR_W | Byte address of the write target |
| cmd_data | input | 16 | Write data; byte writes use bits [7:0] |
| vpp_ok | input | 1 | External programming supply is in range |
| arr_addr | output | ADDR_W | Array address (target, or scan address while erasing) |
| arr_wdata | output | 16 | Data to write; a byte is replicated on both lanes |
| arr_be | output | 2 | Lane enables, bit 1 = even byte |
| arr_prog_en | output | 1 | Write pulse strobe |
| arr_erase_en | output | 1 | Bulk erase pulse strobe |
| arr_rdata | input | 16 | Combinational read-back of the word at arr_addr |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle success pulse |
| fail | output | 1 | One-cycle failure pulse |

## Verification
The bench models the array as a memory whose cells change state only after a chosen number of pulses. This lets it place verification success at the first pulse, at a middle pulse, exactly at the budget, or never. A sequencer that stopped at the first match, or that counted margin pulses against the budget, would show the wrong total pulse count. So would one that gave up one pulse early or late at the boundary. The bench checks that odd and even byte writes leave the neighbouring byte alone, which catches a swapped lane mapping. It refuses misaligned and reserved commands. It drops the supply both before a transfer and in the middle of a pulse, which exposes a design that keeps the strobe up or reports late. It also holds a second command on the port while busy, so a design that latched it would erase a planted byte.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    OP_BYTE  = 2'b00,
    OP_WORD  = 2'b01,
    OP_ERASE = 2'b10,
    OP_RSVD  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PULSE  = 2'd1,
    ST_SETTLE = 2'd2,
    ST_VERIFY = 2'd3
  } st_e;
endpackage

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
  parameter int TW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load)       cnt_q <= load_val;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/flash_seq_verify.sv
module flash_seq_verify
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_start,
  input  logic              scan_step,
  input  logic              erase_mode,
  input  logic              byte_mode,
  input  logic              odd_lane,
  input  logic [WORD_W-1:0] tgt_data,
  input  logic [WORD_W-1:0] rdata,
  output logic [ADDR_W-1:0] scan_addr,
  output logic              scan_last,
  output logic [1:0]        lane_be,
  output logic [WORD_W-1:0] wr_word,
  output logic              match
);
  localparam int WA_W = ADDR_W - 1;

  logic [WA_W-1:0]   word_q;
  logic [WORD_W-1:0] mask;
  logic [WORD_W-1:0] expect_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          word_q <= '0;
    else if (scan_start) word_q <= '0;
    else if (scan_step)  word_q <= word_q + 1'b1;
  end

  assign scan_addr = {word_q, 1'b0};
  assign scan_last = &word_q;

  always_comb begin
    if (erase_mode)     lane_be = 2'b11;
    else if (byte_mode) lane_be = odd_lane ? 2'b01 : 2'b10;
    else                lane_be = 2'b11;
  end

  assign wr_word  = byte_mode ? {tgt_data[7:0], tgt_data[7:0]} : tgt_data;
  assign mask     = {{8{lane_be[1]}}, {8{lane_be[0]}}};
  assign expect_w = erase_mode ? {WORD_W{1'b1}} : wr_word;
  assign match    = (((rdata ^ expect_w) & mask) == '0);
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int TW        = 20,
  parameter int CW        = 6,
  parameter int PP_CYC    = 200,
  parameter int PS_CYC    = 80,
  parameter int EP_CYC    = 800000,
  parameter int ES_CYC    = 8000,
  parameter int PROG_MAX  = 50,
  parameter int ERASE_MAX = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [WORD_W-1:0] cmd_data,
  input  logic              vpp_ok,
  input  logic              tmr_expired,
  input  logic              vfy_match,
  input  logic              scan_last,
  output logic              cmd_ready,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic              prog_en,
  output logic              erase_en,
  output logic              tmr_load,
  output logic [TW-1:0]     tmr_val,
  output logic              scan_start,
  output logic              scan_step,
  output logic              erase_mode,
  output logic              byte_mode,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [WORD_W-1:0] tgt_data
);
  localparam logic [TW-1:0] PP_M1 = TW'(PP_CYC - 1);
  localparam logic [TW-1:0] PS_M1 = TW'(PS_CYC - 1);
  localparam logic [TW-1:0] EP_M1 = TW'(EP_CYC - 1);
  localparam logic [TW-1:0] ES_M1 = TW'(ES_CYC - 1);
  localparam logic [CW-1:0] P_LIM = CW'(PROG_MAX);
  localparam logic [CW-1:0] E_LIM = CW'(ERASE_MAX);

  st_e               st_q, st_d;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] data_q;
  logic [CW-1:0]     used_q, used_d;
  logic [CW-1:0]     left_q, left_d;
  logic              mgn_q, mgn_d;
  logic              done_d, fail_d, take;

  logic              is_erase;
  logic [TW-1:0]     pulse_m1, settle_m1;
  logic [CW-1:0]     limit;
  op_e               new_op;
  logic              bad_cmd;

  assign is_erase  = (op_q == OP_ERASE);
  assign pulse_m1  = is_erase ? EP_M1 : PP_M1;
  assign settle_m1 = is_erase ? ES_M1 : PS_M1;
  assign limit     = is_erase ? E_LIM : P_LIM;
  assign new_op    = op_e'(cmd_op);
  assign bad_cmd   = !vpp_ok || (new_op == OP_RSVD) ||
                     ((new_op == OP_WORD) && cmd_addr[0]);

  always_comb begin
    st_d       = st_q;
    used_d     = used_q;
    left_d     = left_q;
    mgn_d      = mgn_q;
    done_d     = 1'b0;
    fail_d     = 1'b0;
    take       = 1'b0;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    scan_start = 1'b0;
    scan_step  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          take = 1'b1;
          if (bad_cmd) begin
            fail_d = 1'b1;
          end else begin
            st_d     = ST_PULSE;
            used_d   = '0;
            left_d   = '0;
            mgn_d    = 1'b0;
            tmr_load = 1'b1;
            tmr_val  = (new_op == OP_ERASE) ? EP_M1 : PP_M1;
          end
        end
      end
      ST_PULSE: begin
        if (tmr_expired) begin
          st_d     = ST_SETTLE;
          tmr_load = 1'b1;
          tmr_val  = settle_m1;
          if (mgn_q) left_d = left_q - 1'b1;
          else       used_d = used_q + 1'b1;
        end
      end
      ST_SETTLE: begin
        if (tmr_expired) begin
          if (mgn_q) begin
            if (left_q == '0) begin
              st_d   = ST_IDLE;
              done_d = 1'b1;
            end else begin
              st_d     = ST_PULSE;
              tmr_load = 1'b1;
              tmr_val  = pulse_m1;
            end
          end else begin
            st_d       = ST_VERIFY;
            scan_start = 1'b1;
          end
        end
      end
      ST_VERIFY: begin
        if (!vfy_match) begin
          if (used_q == limit) begin
            st_d   = ST_IDLE;
            fail_d = 1'b1;
          end else begin
            st_d     = ST_PULSE;
            tmr_load = 1'b1;
            tmr_val  = pulse_m1;
          end
        end else if (!is_erase || scan_last) begin
          st_d     = ST_PULSE;
          mgn_d    = 1'b1;
          left_d   = used_q;
          tmr_load = 1'b1;
          tmr_val  = pulse_m1;
        end else begin
          scan_step = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if ((st_q != ST_IDLE) && !vpp_ok) begin
      st_d      = ST_IDLE;
      fail_d    = 1'b1;
      done_d    = 1'b0;
      tmr_load  = 1'b0;
      scan_step = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_BYTE;
      addr_q <= '0;
      data_q <= '0;
      used_q <= '0;
      left_q <= '0;
      mgn_q  <= 1'b0;
      done   <= 1'b0;
      fail   <= 1'b0;
    end else begin
      st_q   <= st_d;
      used_q <= used_d;
      left_q <= left_d;
      mgn_q  <= mgn_d;
      done   <= done_d;
      fail   <= fail_d;
      if (take) begin
        op_q   <= new_op;
        addr_q <= cmd_addr;
        data_q <= cmd_data;
      end
    end
  end

  assign busy       = (st_q != ST_IDLE);
  assign cmd_ready  = !busy;
  assign prog_en    = (st_q == ST_PULSE) && !is_erase;
  assign erase_en   = (st_q == ST_PULSE) && is_erase;
  assign erase_mode = is_erase;
  assign byte_mode  = (op_q == OP_BYTE);
  assign tgt_addr   = addr_q;
  assign tgt_data   = data_q;
endmodule

// File: rtl/flash_pulse_seq.sv
module flash_pulse_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W          = 15,
  parameter int CYC_PER_US      = 8,
  parameter int PROG_PULSE_US   = 25,
  parameter int PROG_SETTLE_US  = 10,
  parameter int ERASE_PULSE_US  = 100000,
  parameter int ERASE_SETTLE_US = 1000,
  parameter int PROG_MAX        = 50,
  parameter int ERASE_MAX       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [15:0]       cmd_data,
  input  logic              vpp_ok,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [15:0]       arr_wdata,
  output logic [1:0]        arr_be,
  output logic              arr_prog_en,
  output logic              arr_erase_en,
  input  logic [15:0]       arr_rdata,
  output logic              busy,
  output logic              done,
  output logic              fail
);
  localparam int PP_CYC  = PROG_PULSE_US * CYC_PER_US;
  localparam int PS_CYC  = PROG_SETTLE_US * CYC_PER_US;
  localparam int EP_CYC  = ERASE_PULSE_US * CYC_PER_US;
  localparam int ES_CYC  = ERASE_SETTLE_US * CYC_PER_US;
  localparam int MAX_P   = (PP_CYC > PS_CYC) ? PP_CYC : PS_CYC;
  localparam int MAX_E   = (EP_CYC > ES_CYC) ? EP_CYC : ES_CYC;
  localparam int MAX_CYC = (MAX_P > MAX_E) ? MAX_P : MAX_E;
  localparam int TW      = $clog2(MAX_CYC + 1);
  localparam int MAX_N   = (PROG_MAX > ERASE_MAX) ? PROG_MAX : ERASE_MAX;
  localparam int CW      = $clog2(MAX_N + 1);

  logic              tmr_load, tmr_expired;
  logic [TW-1:0]     tmr_val;
  logic              scan_start, scan_step, scan_last;
  logic              erase_mode, byte_mode, vfy_match;
  logic [ADDR_W-1:0] tgt_addr, scan_addr;
  logic [WORD_W-1:0] tgt_data;

  flash_seq_ctrl #(
    .ADDR_W(ADDR_W), .TW(TW), .CW(CW),
    .PP_CYC(PP_CYC), .PS_CYC(PS_CYC), .EP_CYC(EP_CYC), .ES_CYC(ES_CYC),
    .PROG_MAX(PROG_MAX), .ERASE_MAX(ERASE_MAX)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .vpp_ok(vpp_ok),
    .tmr_expired(tmr_expired), .vfy_match(vfy_match), .scan_last(scan_last),
    .cmd_ready(cmd_ready), .busy(busy), .done(done), .fail(fail),
    .prog_en(arr_prog_en), .erase_en(arr_erase_en),
    .tmr_load(tmr_load), .tmr_val(tmr_val),
    .scan_start(scan_start), .scan_step(scan_step),
    .erase_mode(erase_mode), .byte_mode(byte_mode),
    .tgt_addr(tgt_addr), .tgt_data(tgt_data)
  );

  flash_seq_timer #(.TW(TW)) timer_i (
    .clk(clk), .rst_n(rst_n),
    .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
  );

  flash_seq_verify #(.ADDR_W(ADDR_W)) verify_i (
    .clk(clk), .rst_n(rst_n),
    .scan_start(scan_start), .scan_step(scan_step),
    .erase_mode(erase_mode), .byte_mode(byte_mode), .odd_lane(tgt_addr[0]),
    .tgt_data(tgt_data), .rdata(arr_rdata),
    .scan_addr(scan_addr), .scan_last(scan_last),
    .lane_be(arr_be), .wr_word(arr_wdata), .match(vfy_match)
  );

  assign arr_addr = erase_mode ? scan_addr : tgt_addr;
endmodule

// File: rtl/flash_pulse_seq_chk.sv
module flash_pulse_seq_chk #(
  parameter int ADDR_W    = 15,
  parameter int PROG_MAX  = 50,
  parameter int ERASE_MAX = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              vpp_ok,
  input logic              arr_prog_en,
  input logic              arr_erase_en,
  input logic              busy,
  input logic              done,
  input logic              fail
);
  localparam int PCW = $clog2(2 * PROG_MAX + 2);
  localparam int ECW = $clog2(2 * ERASE_MAX + 2);

  logic           prog_d, erase_d;
  logic [PCW-1:0] prog_n;
  logic [ECW-1:0] erase_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_d  <= 1'b0;
      erase_d <= 1'b0;
      prog_n  <= '0;
      erase_n <= '0;
    end else begin
      prog_d  <= arr_prog_en;
      erase_d <= arr_erase_en;
      if (cmd_valid && cmd_ready) begin
        prog_n  <= '0;
        erase_n <= '0;
      end else begin
        if (arr_prog_en && !prog_d)   prog_n  <= prog_n + 1'b1;
        if (arr_erase_en && !erase_d) erase_n <= erase_n + 1'b1;
      end
    end
  end

  a_r1_start_needs_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid && cmd_ready));

  a_r2_misaligned_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 2'b01 && cmd_addr[0])
      |=> (fail && !busy && !arr_prog_en));

  a_r6_prog_budget: assert property (@(posedge clk) disable iff (!rst_n)
    int'(prog_n) <= 2 * PROG_MAX);

  a_r8_erase_budget: assert property (@(posedge clk) disable iff (!rst_n)
    int'(erase_n) <= 2 * ERASE_MAX);

  a_r9_supply_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !vpp_ok) |=> (fail && !busy && !arr_prog_en && !arr_erase_en));

  a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_prog_en && arr_erase_en));

  a_r10_strobe_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_prog_en || arr_erase_en) |-> busy);

  a_r10_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_fail_single: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> !fail);
endmodule

bind flash_pulse_seq flash_pulse_seq_chk #(
  .ADDR_W(ADDR_W), .PROG_MAX(PROG_MAX), .ERASE_MAX(ERASE_MAX)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_addr(cmd_addr), .vpp_ok(vpp_ok),
  .arr_prog_en(arr_prog_en), .arr_erase_en(arr_erase_en),
  .busy(busy), .done(done), .fail(fail)
);

// File: tb/flash_pulse_seq_tb_top.sv
module flash_pulse_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 6;
  localparam int NB   = 1 << AW;
  localparam int CPU  = 2;
  localparam int PP_W = 25 * CPU;
  localparam int PS_W = 10 * CPU;
  localparam int EP_W = 50 * CPU;
  localparam int ES_W = 10 * CPU;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'b00;
  logic [AW-1:0] cmd_addr = '0;
  logic [15:0]   cmd_data = '0;
  logic          vpp_ok = 1'b1;
  logic          cmd_ready, arr_prog_en, arr_erase_en, busy, done, fail;
  logic [AW-1:0] arr_addr;
  logic [15:0]   arr_wdata, arr_rdata;
  logic [1:0]    arr_be;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_pulse_seq #(
    .ADDR_W(AW), .CYC_PER_US(CPU), .ERASE_PULSE_US(50), .ERASE_SETTLE_US(10)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .vpp_ok(vpp_ok),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_be(arr_be),
    .arr_prog_en(arr_prog_en), .arr_erase_en(arr_erase_en),
    .arr_rdata(arr_rdata), .busy(busy), .done(done), .fail(fail)
  );

  // Behavioural array: cells change only after a chosen number of pulses.
  logic [7:0] mem [NB];
  int tok = 0, seen_tok = 0;
  int need_p = 1, need_e = 1, fill_v = 8'hFF, poke_a = -1, poke_v = 0;
  int hits_p = 0, hits_e = 0;
  int np = 0, ne = 0, bad_pw = 0, bad_ew = 0, bad_pg = 0, bad_eg = 0;
  int wp = 0, we = 0, gp = 0, ge = 0;
  logic [AW-1:0] cap_a;
  logic [15:0]   cap_d;
  logic [1:0]    cap_be;

  assign arr_rdata = {mem[{arr_addr[AW-1:1], 1'b0}], mem[{arr_addr[AW-1:1], 1'b1}]};

  always @(negedge clk) begin
    if (tok != seen_tok) begin
      seen_tok = tok;
      for (int i = 0; i < NB; i++) mem[i] = fill_v[7:0];
      if (poke_a >= 0) mem[poke_a] = poke_v[7:0];
      hits_p = 0;
      hits_e = 0;
    end
    if (arr_prog_en) begin
      if (wp == 0 && np > 0 && gp < PS_W) bad_pg++;
      wp++;
      gp = 0;
      cap_a = arr_addr; cap_d = arr_wdata; cap_be = arr_be;
    end else if (wp > 0) begin
      np++;
      if (wp != PP_W) bad_pw++;
      wp = 0;
      hits_p++;
      if (hits_p >= need_p) begin
        if (cap_be[1]) mem[{cap_a[AW-1:1], 1'b0}] = mem[{cap_a[AW-1:1], 1'b0}] & cap_d[15:8];
        if (cap_be[0]) mem[{cap_a[AW-1:1], 1'b1}] = mem[{cap_a[AW-1:1], 1'b1}] & cap_d[7:0];
      end
      gp = 1;
    end else gp++;
    if (arr_erase_en) begin
      if (we == 0 && ne > 0 && ge < ES_W) bad_eg++;
      we++;
      ge = 0;
    end else if (we > 0) begin
      ne++;
      if (we != EP_W) bad_ew++;
      we = 0;
      hits_e++;
      if (hits_e >= need_e) for (int i = 0; i < NB; i++) mem[i] = 8'hFF;
      ge = 1;
    end else ge++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic prep(input int p, input int e, input int fill, input int pa, input int pv);
    need_p = p; need_e = e; fill_v = fill; poke_a = pa; poke_v = pv;
    tok++;
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input logic [1:0] op, input int a, input logic [15:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = AW'(a); cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_end(output bit got_done, output bit got_fail);
    int n = 0;
    while (!done && !fail && n < 20000) begin
      @(negedge clk);
      n++;
    end
    got_done = done; got_fail = fail;
    check(!busy, "R10 busy low at status pulse", int'(busy), 0);
    @(negedge clk);
    check(!done && !fail, "R10 status lasts one cycle", int'({done, fail}), 0);
  endtask

  task automatic t_reset();
    check(cmd_ready && !busy, "R1 idle after reset", int'({cmd_ready, busy}), 2);
    check(!done && !fail && !arr_prog_en && !arr_erase_en, "R10 outputs low after reset",
          int'({done, fail, arr_prog_en, arr_erase_en}), 0);
  endtask

  task automatic t_prog(input logic [1:0] op, input int a, input logic [15:0] d,
                        input int need, input int b0, input int b1);
    int p0 = np, w0 = bad_pw, g0 = bad_pg;
    bit gd, gf;
    prep(need, 1, 8'hFF, -1, 0);
    send(op, a, d);
    check(busy && !cmd_ready, "R10 busy after transfer", int'({busy, cmd_ready}), 2);
    wait_end(gd, gf);
    check(gd && !gf, "R5 write completes", int'({gd, gf}), 2);
    check(np - p0 == 2 * need, "R5 margin doubles pulses", np - p0, 2 * need);
    check(bad_pw == w0, "R3 write pulse width", bad_pw - w0, 0);
    check(bad_pg == g0, "R3 settle gap", bad_pg - g0, 0);
    check(mem[a & ~1] == b0[7:0], "R4 even byte", mem[a & ~1], b0);
    check(mem[a | 1] == b1[7:0], "R4 odd byte", mem[a | 1], b1);
  endtask

  task automatic t_refuse(input logic [1:0] op, input int a);
    int p0 = np;
    bit gd, gf;
    prep(1, 1, 8'hFF, -1, 0);
    send(op, a, 16'h0000);
    check(fail && !busy, "R2 refused command fails", int'({fail, busy}), 2);
    wait_end(gd, gf);
    check(np == p0 && arr_rdata == 16'hFFFF, "R2 no pulse on refusal", np - p0, 0);
  endtask

  task automatic t_budget();
    int p0 = np;
    bit gd, gf;
    prep(999, 1, 8'hFF, -1, 0);
    send(2'b00, 7, 16'h0011);
    wait_end(gd, gf);
    check(gf && !gd, "R6 budget exhausted fails", int'({gd, gf}), 1);
    check(np - p0 == 50, "R6 pulse count at failure", np - p0, 50);
    check(mem[7] == 8'hFF, "R6 cell untouched", mem[7], 8'hFF);
  endtask

  task automatic t_erase(input int need, input bit expect_ok);
    int e0 = ne, w0 = bad_ew, g0 = bad_eg, ff = 1;
    bit gd, gf;
    prep(1, need, 8'h5A, 0, 8'h00);
    send(2'b10, 0, 16'h0000);
    wait_end(gd, gf);
    for (int i = 0; i < NB; i++) if (mem[i] != 8'hFF) ff = 0;
    if (expect_ok) begin
      check(gd && !gf, "R7 erase completes", int'({gd, gf}), 2);
      check(ne - e0 == 2 * need, "R8 erase margin pulses", ne - e0, 2 * need);
      check(ff == 1, "R7 array all erased", ff, 1);
      check(bad_ew == w0, "R7 erase pulse width", bad_ew - w0, 0);
      check(bad_eg == g0, "R7 erase settle gap", bad_eg - g0, 0);
    end else begin
      check(gf && !gd, "R8 erase budget fails", int'({gd, gf}), 1);
      check(ne - e0 == 5, "R8 erase pulse count", ne - e0, 5);
    end
  endtask

  task automatic t_vpp_start();
    int p0 = np;
    bit gd, gf;
    prep(1, 1, 8'hFF, -1, 0);
    vpp_ok = 1'b0;
    send(2'b00, 3, 16'h0000);
    check(fail && !busy, "R9 low supply refuses", int'({fail, busy}), 2);
    wait_end(gd, gf);
    vpp_ok = 1'b1;
    check(np == p0, "R9 no pulse with low supply", np - p0, 0);
  endtask

  task automatic t_vpp_drop();
    prep(999, 1, 8'hFF, -1, 0);
    send(2'b00, 9, 16'h0000);
    while (!arr_prog_en) @(negedge clk);
    repeat (3) @(negedge clk);
    vpp_ok = 1'b0;
    @(negedge clk);
    check(fail && !busy && !arr_prog_en, "R9 abort on supply loss",
          int'({fail, busy, arr_prog_en}), 4);
    vpp_ok = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_busy_ignore();
    int e0 = ne, nr = 0;
    bit gd, gf;
    prep(1, 1, 8'hFF, 30, 8'h00);
    send(2'b00, 20, 16'h0055);
    cmd_valid = 1'b1; cmd_op = 2'b10; cmd_addr = '0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (cmd_ready) nr++;
    end
    cmd_valid = 1'b0;
    check(nr == 0, "R1 not ready while busy", nr, 0);
    wait_end(gd, gf);
    check(gd && ne == e0, "R1 held command ignored", ne - e0, 0);
    check(mem[30] == 8'h00 && mem[20] == 8'h55, "R1 array unchanged by held command",
          {mem[30], mem[20]}, 16'h0055);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prog(2'b00, 5, 16'h00A5, 3, 8'hFF, 8'hA5);
    t_prog(2'b00, 8, 16'h003C, 1, 8'h3C, 8'hFF);
    t_prog(2'b01, 10, 16'h1234, 2, 8'h12, 8'h34);
    t_prog(2'b00, 17, 16'h0042, 50, 8'hFF, 8'h42);
    t_refuse(2'b01, 13);
    t_refuse(2'b11, 4);
    t_budget();
    t_erase(2, 1'b1);
    t_erase(9, 1'b0);
    t_vpp_start();
    t_vpp_drop();
    t_busy_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule